// File: doc/BRIEF.md
# Forward-Link Field Modulator

This block sends a bit sequence from a reader to a low-frequency tag by switching the reader's carrier field on and off. Time is counted in carrier cycles. A one-clock `carrier_tick` strobe, produced elsewhere, marks each 125 kHz carrier cycle. The caller supplies the following with a start pulse, and the block latches all of them:

- up to `MAX_BITS` bits, one bit per vector position;
- a bit count;
- a 4-bit command code;
- a settle time.

The block turns the field on for a short lead-in. It then sends each bit in its own fixed-length slot. A 1 keeps the field on for the whole slot. A 0 cuts the field for a notch and then restores it for the rest of the slot. After the last slot the field stays on, and `done` pulses for one clock.

Commands that change tag memory need a pause before the reply is captured. For these commands the block counts the settle time in carrier cycles and then pulses `capture_go`. For every other command, `capture_go` pulses together with `done`. Assembling the command bits and capturing the reply are handled outside this block.

Top module: `fwd_link_modulator`

## Requirements
- R1: After reset, `field_on`, `busy`, `done` and `capture_go` are all 0.
- R2: When `start` is accepted, `field_on` rises on that clock edge and stays 1 for exactly 18 carrier ticks (the lead-in). The first bit slot begins at the edge of the 18th tick.
- R3: A bit of value 1 keeps `field_on` at 1 for all 32 ticks of its slot.
- R4: A bit of value 0 drives `field_on` to 0 for the first 23 ticks of its slot and to 1 for the remaining 9 ticks.
- R5: Slots are sent for `bits_in[0]`, `bits_in[1]`, and so on, in rising index order, for the latched count only. Positions at or above the count have no effect on `field_on`.
- R6: A bit count of 0 produces only the 18-tick lead-in, followed by `done`.
- R7: A bit count above `MAX_BITS` (64) is treated as `MAX_BITS`.
- R8: `done` is high for exactly one clock, in the clock after the edge that ends the last tick of the sequence. `field_on` stays 1 from then until the next accepted start.
- R9: A `start` pulse while `busy` is 1 is ignored. The sequence in progress, including its bits and count, continues unchanged.
- R10: The settle wait applies only to command codes 4'hA (write) and 4'h3 (protect). For these codes, `capture_go` pulses for one clock after `settle_ticks` further carrier ticks have been counted following `done`. For any other code, including 4'h9 (read) and 4'h5 (disable), `capture_go` pulses in the same clock as `done`.
- R11: With `settle_ticks` equal to 0, `capture_go` pulses in the same clock as `done` for every command code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_tick | input | 1 | One-clock strobe, one per carrier cycle |
| start | input | 1 | Begin a sequence; accepted only when `busy` is 0 |
| cmd_code | input | 4 | Command code, used to decide whether the settle wait applies |
| bit_count | input | CNT_W (7) | Number of bits to send |
| bits_in | input | MAX_BITS (64) | Bit values, with position 0 sent first |
| settle_ticks | input | SETTLE_W (16) | Settle wait in carrier ticks for write and protect commands |
| field_on | output | 1 | Reader field enable |
| busy | output | 1 | High while a sequence or a settle wait is in progress |
| done | output | 1 | One-clock pulse at the end of the last slot |
| capture_go | output | 1 | One-clock pulse that opens the reply capture |

## Verification
The bench samples `field_on` once per carrier tick and compares the whole field waveform with one built from R2 to R4. This finds any notch or lead-in that is one tick too long or too short, and any bit order that is reversed or taken from the wrong end of the vector.

A count of 0 and a count above 64 are tested. A design that underflows its bit index would send spurious slots for the first case, and one that does not clamp would run past the top of the vector for the second.

A second start is issued in the middle of a sequence, with a different pattern on the inputs. A design that does not latch its inputs, or that restarts on this pulse, would change the waveform.

The distance from `done` to `capture_go` is measured in ticks for write, protect, disable and a zero settle time. An off-by-one in the settle counter, or a wait applied to the wrong command, shows up as a wrong tick count.

// File: rtl/fwd_link_pkg.sv
package fwd_link_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD,
      PH_NOTCH,
      PH_RECOVER,
      PH_MARK
   } phase_e;

   localparam logic [3:0] CMD_WRITE   = 4'hA;
   localparam logic [3:0] CMD_READ    = 4'h9;
   localparam logic [3:0] CMD_DISABLE = 4'h5;
   localparam logic [3:0] CMD_PROTECT = 4'h3;

   function automatic logic cmd_needs_settle(input logic [3:0] code);
      return (code == CMD_WRITE) || (code == CMD_PROTECT);
   endfunction

endpackage

// File: rtl/fwd_phase_timer.sv
module fwd_phase_timer #(
   parameter int TW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          run,
   input  logic          tick,
   input  logic [TW-1:0] limit,
   output logic          last
);
   logic [TW-1:0] cnt_q;

   assign last = run & tick & (cnt_q == limit - TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear)          cnt_q <= '0;
      else if (run && tick)    cnt_q <= last ? '0 : cnt_q + TW'(1);
   end

   AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < limit)); // R4

endmodule

// File: rtl/fwd_bit_picker.sv
module fwd_bit_picker #(
   parameter int NBITS = 64,
   parameter int IW    = 6
) (
   input  logic [NBITS-1:0] vec,
   input  logic [IW-1:0]    sel,
   output logic             bit_o
);
   generate
      if (NBITS == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel;
         assign bit_o = vec[0];
      end else begin : g_mux
         always_comb begin
            bit_o = 1'b0;
            for (int i = 0; i < NBITS; i++)
               if (sel == IW'(i)) bit_o = vec[i];
         end
      end
   endgenerate
endmodule

// File: rtl/fwd_settle_timer.sv
module fwd_settle_timer #(
   parameter int SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          tick,
   input  logic [SW-1:0] ticks,
   output logic          active,
   output logic          fire
);
   logic [SW-1:0] cnt_q;
   logic          act_q, fire_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         act_q  <= 1'b0;
         fire_q <= 1'b0;
      end else begin
         fire_q <= 1'b0;
         if (arm) begin
            cnt_q <= '0;
            act_q <= 1'b1;
         end else if (act_q && tick) begin
            if (cnt_q == ticks - SW'(1)) begin
               act_q  <= 1'b0;
               fire_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + SW'(1);
            end
         end
      end
   end

   assign active = act_q;
   assign fire   = fire_q;

   AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_q |=> !fire_q); // R10
   AST_FIRE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      fire_q |-> $past(act_q)); // R10

endmodule

// File: rtl/fwd_link_modulator.sv
module fwd_link_modulator
   import fwd_link_pkg::*;
#(
   parameter int MAX_BITS    = 64,
   parameter int LEAD_TICKS  = 18,
   parameter int SLOT_TICKS  = 32,
   parameter int NOTCH_TICKS = 23,
   parameter int SETTLE_W    = 16,
   localparam int CNT_W      = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                carrier_tick,
   input  logic                start,
   input  logic [3:0]          cmd_code,
   input  logic [CNT_W-1:0]    bit_count,
   input  logic [MAX_BITS-1:0] bits_in,
   input  logic [SETTLE_W-1:0] settle_ticks,
   output logic                field_on,
   output logic                busy,
   output logic                done,
   output logic                capture_go
);
   localparam int IDX_W     = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
   localparam int RECOVER_T = SLOT_TICKS - NOTCH_TICKS;
   localparam int LONGEST   = (LEAD_TICKS > SLOT_TICKS) ? LEAD_TICKS : SLOT_TICKS;
   localparam int TW        = $clog2(LONGEST + 1);

   generate
      if (NOTCH_TICKS < 1 || NOTCH_TICKS >= SLOT_TICKS) begin : g_bad_notch
         $error("NOTCH_TICKS must lie in 1..SLOT_TICKS-1");
      end
      if (LEAD_TICKS < 1) begin : g_bad_lead
         $error("LEAD_TICKS must be at least 1");
      end
      if (MAX_BITS < 1) begin : g_bad_bits
         $error("MAX_BITS must be at least 1");
      end
      if (SETTLE_W < 1) begin : g_bad_settle
         $error("SETTLE_W must be at least 1");
      end
   endgenerate

   phase_e              ph_q, ph_d;
   logic [MAX_BITS-1:0] bits_q;
   logic [CNT_W-1:0]    lim_q, idx_q, sel_idx;
   logic [SETTLE_W-1:0] settle_q;
   logic                need_q, field_q, done_q;
   logic                accept, launch, finish, more, nxt_bit, last;
   logic                settle_act, settle_fire, wait_used;
   logic [TW-1:0]       ph_limit;

   assign busy   = (ph_q != PH_IDLE) | settle_act;
   assign accept = start & ~busy;

   // phase length in carrier ticks
   always_comb begin
      unique case (ph_q)
         PH_LEAD:    ph_limit = TW'(LEAD_TICKS);
         PH_NOTCH:   ph_limit = TW'(NOTCH_TICKS);
         PH_RECOVER: ph_limit = TW'(RECOVER_T);
         PH_MARK:    ph_limit = TW'(SLOT_TICKS);
         default:    ph_limit = TW'(1);
      endcase
   end

   fwd_phase_timer #(.TW(TW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .run   (ph_q != PH_IDLE),
      .tick  (carrier_tick),
      .limit (ph_limit),
      .last  (last)
   );

   // index of the bit whose slot would start next
   assign sel_idx = (ph_q == PH_LEAD) ? '0 : idx_q + CNT_W'(1);
   assign more    = (sel_idx < lim_q);

   fwd_bit_picker #(.NBITS(MAX_BITS), .IW(IDX_W)) u_pick (
      .vec   (bits_q),
      .sel   (sel_idx[IDX_W-1:0]),
      .bit_o (nxt_bit)
   );

   always_comb begin
      ph_d   = ph_q;
      launch = 1'b0;
      finish = 1'b0;
      unique case (ph_q)
         PH_IDLE:  if (accept) ph_d = PH_LEAD;
         PH_NOTCH: if (last)   ph_d = PH_RECOVER;
         PH_LEAD, PH_RECOVER, PH_MARK: begin
            if (last) begin
               if (more) launch = 1'b1;
               else      finish = 1'b1;
            end
         end
         default: ph_d = PH_IDLE;
      endcase
      if (launch) ph_d = nxt_bit ? PH_MARK : PH_NOTCH;
      if (finish) ph_d = PH_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         bits_q   <= '0;
         lim_q    <= '0;
         idx_q    <= '0;
         settle_q <= '0;
         need_q   <= 1'b0;
         field_q  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         done_q <= finish;
         if (accept) begin
            bits_q   <= bits_in;
            lim_q    <= (bit_count > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : bit_count;
            idx_q    <= '0;
            settle_q <= settle_ticks;
            need_q   <= cmd_needs_settle(cmd_code);
            field_q  <= 1'b1;
         end else if (launch) begin
            idx_q   <= sel_idx;
            field_q <= nxt_bit;
         end else if (ph_q == PH_NOTCH && last) begin
            field_q <= 1'b1;
         end
      end
   end

   assign wait_used = need_q & (settle_q != '0);

   fwd_settle_timer #(.SW(SETTLE_W)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (finish & wait_used),
      .tick   (carrier_tick),
      .ticks  (settle_q),
      .active (settle_act),
      .fire   (settle_fire)
   );

   assign field_on   = field_q;
   assign done       = done_q;
   assign capture_go = (done_q & ~wait_used) | settle_fire;

   AST_LEAD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_LEAD) |-> field_q); // R2
   AST_MARK_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_MARK) |-> field_q); // R3
   AST_DROP_IN_NOTCH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(field_q) |-> (ph_q == PH_NOTCH)); // R4
   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q inside {PH_NOTCH, PH_RECOVER, PH_MARK}) |-> (idx_q < lim_q)); // R5
   AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_LEAD && lim_q == '0) |=> (ph_q inside {PH_LEAD, PH_IDLE})); // R6
   AST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      lim_q <= CNT_W'(MAX_BITS)); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_IDLE && $past(ph_q) == PH_IDLE) |-> $stable(field_q)); // R8
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> ($stable(bits_q) && $stable(lim_q))); // R9
   AST_CAPTURE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      capture_go |-> (done_q || $past(settle_act))); // R10

endmodule

// File: tb/fwd_link_modulator_tb.sv
`timescale 1ns/100ps
module fwd_link_modulator_tb_top;
   localparam int MAXB = 64;
   localparam int CW   = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            carrier_tick = 1'b0;
   logic            start = 1'b0;
   logic [3:0]      cmd_code = 4'h9;
   logic [CW-1:0]   bit_count = '0;
   logic [MAXB-1:0] bits_in = '0;
   logic [15:0]     settle_ticks = '0;
   logic            field_on, busy, done, capture_go;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   bit cap [0:2199];
   bit expv[0:2199];

   fwd_link_modulator dut_i (
      .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .start(start),
      .cmd_code(cmd_code), .bit_count(bit_count), .bits_in(bits_in),
      .settle_ticks(settle_ticks), .field_on(field_on), .busy(busy),
      .done(done), .capture_go(capture_go)
   );

   always #2.5 clk = ~clk;

   // carrier strobe: one clock high out of every three
   initial begin
      int div = 0;
      forever begin
         @(posedge clk);
         #1;
         div = (div == 2) ? 0 : div + 1;
         carrier_tick = (div == 0);
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Sends one sequence and checks waveform, done, field hold and capture timing.
   task automatic run_frame(input logic [3:0] cmd, input int cnt, input logic [63:0] bits,
                            input int settle, input string req, input bit interfere);
      int n, elen, clen, mism, gap, guard, exp_gap;
      bit saw_done;
      n = (cnt > MAXB) ? MAXB : cnt;
      elen = 0;
      for (int k = 0; k < 18; k++) expv[elen++] = 1'b1;
      for (int b = 0; b < n; b++) begin
         if (bits[b]) for (int k = 0; k < 32; k++) expv[elen++] = 1'b1;
         else begin
            for (int k = 0; k < 23; k++) expv[elen++] = 1'b0;
            for (int k = 0; k < 9; k++)  expv[elen++] = 1'b1;
         end
      end
      @(posedge clk); #1;
      cmd_code = cmd; bit_count = CW'(cnt); bits_in = bits; settle_ticks = 16'(settle);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      clen = 0; saw_done = 0; guard = 0;
      while (!saw_done && guard < 20000) begin
         @(negedge clk);
         guard++;
         if (interfere && clen == 40 && carrier_tick) begin
            start = 1'b1; bits_in = ~bits; bit_count = CW'(5); cmd_code = 4'hA;
         end else begin
            start = 1'b0;
         end
         if (done) saw_done = 1;
         else if (carrier_tick && clen < 2200) cap[clen++] = field_on;
      end
      start = 1'b0;
      chk(saw_done, {req, " done seen"}, saw_done, 1);
      chk(clen == elen, {req, " waveform length in ticks"}, clen, elen);
      mism = -1;
      for (int k = 0; k < elen && k < clen; k++)
         if (mism < 0 && cap[k] != expv[k]) mism = k;
      chk(mism < 0, {req, " first mismatching tick"}, mism, -1);
      chk(field_on == 1'b1, "R8 field on at done", field_on, 1);
      exp_gap = ((cmd == 4'hA || cmd == 4'h3) && settle != 0) ? settle : 0;
      gap = 0; guard = 0;
      while (!capture_go && guard < 20000) begin
         if (carrier_tick) gap++;
         @(negedge clk);
         guard++;
         if (done) chk(0, "R8 done width", 2, 1);
      end
      chk(capture_go && gap == exp_gap,
          (exp_gap == 0 && settle == 0) ? "R11 capture ticks after done" : "R10 capture ticks after done",
          gap, exp_gap);
      @(negedge clk);
      chk(capture_go == 1'b0, "R10 capture pulse width", capture_go, 0);
      repeat (20) @(negedge clk);
      chk(field_on == 1'b1 && !busy, "R8 field held on while idle", field_on, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(field_on == 0, "R1 field_on reset", field_on, 0);
      chk(busy == 0, "R1 busy reset", busy, 0);
      chk(done == 0 && capture_go == 0, "R1 done/capture reset", {done, capture_go}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(field_on == 0, "R1 field off before start", field_on, 0);

      run_frame(4'h9, 3, 64'h0, 0, "R4 all-zero bits", 0);
      run_frame(4'h9, 4, 64'hF, 0, "R3 all-one bits", 0);
      run_frame(4'h9, 8, 64'hFFFF_0000_0000_FF4D, 0, "R5 order and unused positions", 0);
      run_frame(4'h9, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R6 zero count", 0);
      run_frame(4'h9, 100, 64'hA5C3_1E07_F00D_6B29, 0, "R7 clamped count", 0);
      run_frame(4'h9, 6, 64'h2D, 0, "R2 lead then bits", 0);
      run_frame(4'hA, 5, 64'h15, 813, "R10 write settle", 0);
      run_frame(4'h3, 2, 64'h2, 7, "R10 protect settle", 0);
      run_frame(4'h5, 3, 64'h5, 50, "R10 disable no settle", 0);
      run_frame(4'hA, 2, 64'h1, 0, "R11 zero settle", 0);
      run_frame(4'h9, 4, 64'h9, 0, "R9 start ignored while busy", 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule